// File: doc/BRIEF.md
# Memory Dependence Wait-Wake Scoreboard

This block decides when each in-flight load or store of an out-of-order core may issue. Every memory instruction arrives with its sequence number, PC, register readiness and a producer guess from an external store-set predictor. The guess is a sequence number, or zero for no guess. An entry can issue only when two conditions hold. Its source operands must be available, and the store it is predicted to follow must have issued. The scoreboard holds waiting entries, keeps one record per in-flight store, and offers the oldest ready entry as the issue candidate.

When the issue stage pops a store, every entry linked to that store gains its memory-ordering condition. The store's record is then freed. A squash with sequence number N removes all entries and store records younger than N. Issue events and ordering violations are forwarded on a predictor report port. Sequence numbers are compared as plain unsigned values, and the number zero is reserved for "no prediction".

Top module: `memdep_scoreboard`

## Requirements
- R1: A legal insert whose predicted store is zero, and whose registers are ready, is the issue candidate (`top_valid`=1, `top_seq` equal to its number) on the cycle after the insert.
- R2: An insert with no store link and registers not ready stays off the candidate output until a register-ready strobe carries its number. It becomes a candidate on the cycle after that strobe.
- R3: An insert whose predicted store is still tracked waits until it has both register readiness and a pop of that store. The later of the two events makes it ready, in either order.
- R4: A nonzero prediction naming a store that is not tracked (never inserted, already issued or squashed) is treated as no dependence.
- R5: The candidate is always the ready entry with the smallest sequence number, whatever the insertion order.
- R6: Popping a store wakes exactly its linked dependents and frees its record. Popping a load wakes nothing.
- R7: An entry inserted with `ins_nonspec`=1 becomes ready only on a non-speculative-ready strobe with its number. A register-ready strobe has no effect on it.
- R8: A squash with number N removes every entry and store record numbered above N and keeps those at or below N.
- R9: While `pop` is high with a candidate present and no squash, `iss_valid` is 1 and `iss_seq`/`iss_pc`/`iss_is_store` describe the candidate. A violation strobe appears unchanged on `pv_valid`/`pv_load_pc`/`pv_store_pc` in the same cycle.
- R10: `ins_kind` encodes 2'b01 = load and 2'b10 = store. Any other code is rejected, nothing is inserted, and `err` pulses high for one cycle after the insert.
- R11: `full` is 1 when all entry slots or all store records are in use. An insert while full, or a store insert whose number is already tracked, is dropped and pulses `err`.
- R12: A squash wins over an insert, pop, register-ready or non-speculative-ready strobe in the same cycle. Those strobes are ignored, `iss_valid` stays 0 and no `err` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert strobe |
| ins_seq | input | SW | Sequence number of the inserted instruction |
| ins_pc | input | PW | PC of the inserted instruction |
| ins_kind | input | 2 | 01 load, 10 store, other codes illegal |
| ins_nonspec | input | 1 | Instruction waits for an explicit release |
| ins_regs_rdy | input | 1 | Operands already available at insert |
| ins_pred_seq | input | SW | Predicted producing store, 0 for none |
| full | output | 1 | No room for another insert |
| rr_valid | input | 1 | Register-ready strobe |
| rr_seq | input | SW | Entry whose operands became ready |
| nsr_valid | input | 1 | Non-speculative release strobe |
| nsr_seq | input | SW | Entry being released |
| top_valid | output | 1 | An issue candidate exists |
| top_seq | output | SW | Candidate sequence number |
| top_pc | output | PW | Candidate PC |
| top_is_store | output | 1 | Candidate is a store |
| pop | input | 1 | Issue the candidate |
| iss_valid | output | 1 | Issue report to predictor |
| iss_seq | output | SW | Issued sequence number |
| iss_pc | output | PW | Issued PC |
| iss_is_store | output | 1 | Issued instruction is a store |
| sq_valid | input | 1 | Squash strobe |
| sq_seq | input | SW | Youngest surviving sequence number |
| vio_valid | input | 1 | Ordering violation detected |
| vio_load_pc | input | PW | PC of the offending load |
| vio_store_pc | input | PW | PC of the store it bypassed |
| pv_valid | output | 1 | Violation report to predictor |
| pv_load_pc | output | PW | Reported load PC |
| pv_store_pc | output | PW | Reported store PC |
| err | output | 1 | One-cycle pulse for a rejected insert |

## Verification
Several cases are hard to reach from the ports. One is a dependent entry that has become register-ready but must still wait on its store. Another is a load pop that has to leave a younger linked entry untouched. The stimulus reaches these by holding the producing store back: the store is inserted with its registers not ready, so the dependents queue behind it. The test then releases the store and the dependents in both orders. For squash, a store, a linked load and an unrelated younger load are built up first, then trimmed in one cut. A later prediction naming the removed store then shows that its record is gone.

// File: rtl/memdep_scoreboard.sv
module memdep_scoreboard #(
  parameter int NE = 16,
  parameter int NS = 8,
  parameter int SW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [SW-1:0] ins_seq,
  input  logic [PW-1:0] ins_pc,
  input  logic [1:0]    ins_kind,
  input  logic          ins_nonspec,
  input  logic          ins_regs_rdy,
  input  logic [SW-1:0] ins_pred_seq,
  output logic          full,
  input  logic          rr_valid,
  input  logic [SW-1:0] rr_seq,
  input  logic          nsr_valid,
  input  logic [SW-1:0] nsr_seq,
  output logic          top_valid,
  output logic [SW-1:0] top_seq,
  output logic [PW-1:0] top_pc,
  output logic          top_is_store,
  input  logic          pop,
  output logic          iss_valid,
  output logic [SW-1:0] iss_seq,
  output logic [PW-1:0] iss_pc,
  output logic          iss_is_store,
  input  logic          sq_valid,
  input  logic [SW-1:0] sq_seq,
  input  logic          vio_valid,
  input  logic [PW-1:0] vio_load_pc,
  input  logic [PW-1:0] vio_store_pc,
  output logic          pv_valid,
  output logic [PW-1:0] pv_load_pc,
  output logic [PW-1:0] pv_store_pc,
  output logic          err
);
  localparam int EIW = (NE > 1) ? $clog2(NE) : 1;
  localparam int SIW = (NS > 1) ? $clog2(NS) : 1;

  logic [NE-1:0] e_v, e_rdy, e_regs, e_mem, e_ns, e_lnk, e_st;
  logic [NE-1:0] n_v, n_rdy, n_regs, n_mem, n_ns, n_lnk, n_st;
  logic [SW-1:0] e_seq [NE], e_lseq [NE], n_seq [NE], n_lseq [NE];
  logic [PW-1:0] e_pc [NE], n_pc [NE];
  logic [NS-1:0] s_v, n_sv;
  logic [SW-1:0] s_seq [NS], n_sseq [NS];

  logic           t_hit, f_hit, sf_hit, dup, pred_hit;
  logic [EIW-1:0] t_idx, f_idx;
  logic [SIW-1:0] sf_idx;
  logic [SW-1:0]  t_seq;
  logic           legal, is_st, ins_ok, do_pop, wake;

  always_comb begin
    t_hit = 1'b0; t_idx = '0; t_seq = '0;
    for (int i = 0; i < NE; i++)
      if (e_v[i] && e_rdy[i] && (!t_hit || e_seq[i] < t_seq)) begin
        t_hit = 1'b1; t_idx = EIW'(i); t_seq = e_seq[i];
      end
    f_hit = 1'b0; f_idx = '0;
    for (int i = NE-1; i >= 0; i--)
      if (!e_v[i]) begin f_hit = 1'b1; f_idx = EIW'(i); end
    sf_hit = 1'b0; sf_idx = '0;
    for (int j = NS-1; j >= 0; j--)
      if (!s_v[j]) begin sf_hit = 1'b1; sf_idx = SIW'(j); end
  end

  assign top_valid    = t_hit;
  assign top_seq      = t_seq;
  assign top_pc       = e_pc[t_idx];
  assign top_is_store = t_hit & e_st[t_idx];

  assign do_pop       = pop & t_hit & ~sq_valid;
  assign wake         = do_pop & e_st[t_idx];
  assign iss_valid    = do_pop;
  assign iss_seq      = t_seq;
  assign iss_pc       = e_pc[t_idx];
  assign iss_is_store = top_is_store;

  assign pv_valid    = vio_valid;
  assign pv_load_pc  = vio_load_pc;
  assign pv_store_pc = vio_store_pc;

  always_comb begin
    dup = 1'b0; pred_hit = 1'b0;
    for (int j = 0; j < NS; j++) begin
      if (s_v[j] && s_seq[j] == ins_seq) dup = 1'b1;
      if (s_v[j] && s_seq[j] == ins_pred_seq) pred_hit = 1'b1;
    end
    if (ins_pred_seq == '0 || (wake && t_seq == ins_pred_seq)) pred_hit = 1'b0;
  end

  assign full   = ~f_hit | ~sf_hit;
  assign legal  = (ins_kind == 2'b01) | (ins_kind == 2'b10);
  assign is_st  = ins_kind == 2'b10;
  assign ins_ok = ins_valid & ~sq_valid & legal & ~full & ~(is_st & dup);

  always_comb begin
    n_v = e_v; n_rdy = e_rdy; n_regs = e_regs; n_mem = e_mem;
    n_ns = e_ns; n_lnk = e_lnk; n_st = e_st;
    n_seq = e_seq; n_lseq = e_lseq; n_pc = e_pc;
    n_sv = s_v; n_sseq = s_seq;
    if (sq_valid) begin
      for (int i = 0; i < NE; i++)
        if (e_v[i] && e_seq[i] > sq_seq) begin n_v[i] = 1'b0; n_lnk[i] = 1'b0; end
      for (int j = 0; j < NS; j++)
        if (s_v[j] && s_seq[j] > sq_seq) n_sv[j] = 1'b0;
    end else begin
      for (int i = 0; i < NE; i++) begin
        if (do_pop && EIW'(i) == t_idx) n_v[i] = 1'b0;
        if (wake && e_lnk[i] && e_lseq[i] == t_seq) begin
          n_mem[i] = 1'b1; n_lnk[i] = 1'b0;
        end
        if (rr_valid && e_seq[i] == rr_seq) n_regs[i] = 1'b1;
        if (nsr_valid && e_ns[i] && e_seq[i] == nsr_seq) n_rdy[i] = 1'b1;
        if (!e_ns[i] && n_regs[i] && n_mem[i]) n_rdy[i] = 1'b1;
      end
      for (int j = 0; j < NS; j++)
        if (wake && s_v[j] && s_seq[j] == t_seq) n_sv[j] = 1'b0;
      if (ins_ok) begin
        n_v[f_idx]    = 1'b1;
        n_seq[f_idx]  = ins_seq;
        n_pc[f_idx]   = ins_pc;
        n_st[f_idx]   = is_st;
        n_ns[f_idx]   = ins_nonspec;
        n_regs[f_idx] = ins_regs_rdy;
        n_lnk[f_idx]  = ~ins_nonspec & pred_hit;
        n_lseq[f_idx] = ins_pred_seq;
        n_mem[f_idx]  = ~ins_nonspec & ~pred_hit;
        n_rdy[f_idx]  = ~ins_nonspec & ~pred_hit & ins_regs_rdy;
        if (is_st) begin
          n_sv[sf_idx]   = 1'b1;
          n_sseq[sf_idx] = ins_seq;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0; e_rdy <= '0; e_regs <= '0; e_mem <= '0;
      e_ns <= '0; e_lnk <= '0; e_st <= '0; s_v <= '0; err <= 1'b0;
    end else begin
      e_v <= n_v; e_rdy <= n_rdy; e_regs <= n_regs; e_mem <= n_mem;
      e_ns <= n_ns; e_lnk <= n_lnk; e_st <= n_st; s_v <= n_sv;
      err <= ins_valid & ~sq_valid & ~ins_ok;
    end
  end

  always_ff @(posedge clk) begin
    e_seq <= n_seq; e_lseq <= n_lseq; e_pc <= n_pc; s_seq <= n_sseq;
  end
endmodule

// File: rtl/memdep_scoreboard_chk.sv
module memdep_scoreboard_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_valid,
  input logic [1:0]    ins_kind,
  input logic          full,
  input logic          rr_valid,
  input logic          nsr_valid,
  input logic          pop,
  input logic          sq_valid,
  input logic [SW-1:0] sq_seq,
  input logic          top_valid,
  input logic [SW-1:0] top_seq,
  input logic          err
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid && !pop && !rr_valid && !nsr_valid && !sq_valid |=> $stable(top_valid) && $stable(top_seq)); // R2
  AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    pop && top_valid && !sq_valid && !ins_valid && !rr_valid && !nsr_valid |=> !top_valid || top_seq > $past(top_seq)); // R5
  AST_SQUASH_TRIMS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !top_valid || top_seq <= $past(sq_seq)); // R8
  AST_BAD_KIND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !sq_valid && (ins_kind == 2'b00 || ins_kind == 2'b11) |=> err); // R10
  AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !sq_valid && full |=> err); // R11
  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> !err); // R12
endmodule

bind memdep_scoreboard memdep_scoreboard_chk #(.SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_kind(ins_kind),
  .full(full), .rr_valid(rr_valid), .nsr_valid(nsr_valid), .pop(pop),
  .sq_valid(sq_valid), .sq_seq(sq_seq), .top_valid(top_valid),
  .top_seq(top_seq), .err(err));

// File: tb/memdep_scoreboard_tb_top.sv
module memdep_scoreboard_tb_top;
  localparam int SW = 8, PW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 0, ins_nonspec = 0, ins_regs_rdy = 0;
  logic [SW-1:0] ins_seq = 0, ins_pred_seq = 0, rr_seq = 0, nsr_seq = 0, sq_seq = 0;
  logic [PW-1:0] ins_pc = 0, vio_load_pc = 0, vio_store_pc = 0;
  logic [1:0] ins_kind = 0;
  logic rr_valid = 0, nsr_valid = 0, pop = 0, sq_valid = 0, vio_valid = 0;
  logic full, top_valid, top_is_store, iss_valid, iss_is_store, pv_valid, err;
  logic [SW-1:0] top_seq, iss_seq;
  logic [PW-1:0] top_pc, iss_pc, pv_load_pc, pv_store_pc;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  memdep_scoreboard dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc),
    .ins_kind(ins_kind), .ins_nonspec(ins_nonspec), .ins_regs_rdy(ins_regs_rdy),
    .ins_pred_seq(ins_pred_seq), .full(full), .rr_valid(rr_valid), .rr_seq(rr_seq),
    .nsr_valid(nsr_valid), .nsr_seq(nsr_seq), .top_valid(top_valid), .top_seq(top_seq),
    .top_pc(top_pc), .top_is_store(top_is_store), .pop(pop), .iss_valid(iss_valid),
    .iss_seq(iss_seq), .iss_pc(iss_pc), .iss_is_store(iss_is_store), .sq_valid(sq_valid),
    .sq_seq(sq_seq), .vio_valid(vio_valid), .vio_load_pc(vio_load_pc),
    .vio_store_pc(vio_store_pc), .pv_valid(pv_valid), .pv_load_pc(pv_load_pc),
    .pv_store_pc(pv_store_pc), .err(err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic top_is(input string tag, input bit v, input int s);
    chk(top_valid == v, {tag, " valid"}, top_valid, v);
    if (v) chk(top_seq == SW'(s), {tag, " seq"}, top_seq, s);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    ins_valid = 0; rr_valid = 0; nsr_valid = 0; pop = 0; sq_valid = 0; vio_valid = 0;
  endtask

  task automatic ins(input int s, input logic [1:0] k, input bit regs, input int pred, input bit ns);
    ins_valid = 1; ins_seq = SW'(s); ins_pc = PW'(s * 4); ins_kind = k;
    ins_regs_rdy = regs; ins_pred_seq = SW'(pred); ins_nonspec = ns;
    tick();
  endtask

  task automatic rr(input int s); rr_valid = 1; rr_seq = SW'(s); tick(); endtask
  task automatic nsr(input int s); nsr_valid = 1; nsr_seq = SW'(s); tick(); endtask
  task automatic popit(); pop = 1; tick(); endtask
  task automatic squash(input int n); sq_valid = 1; sq_seq = SW'(n); tick(); endtask

  task automatic t_reset();
    top_is("R1 reset", 0, 0);
    chk(full == 0, "R11 reset full", full, 0);
    chk(err == 0, "R10 reset err", err, 0);
  endtask

  task automatic t_nodep();
    ins(5, 2'b01, 1, 0, 0);
    top_is("R1 ready at insert", 1, 5);
    pop = 1; #1;
    chk(iss_valid == 1, "R9 iss_valid", iss_valid, 1);
    chk(iss_seq == 5, "R9 iss_seq", iss_seq, 5);
    chk(iss_pc == 20, "R9 iss_pc", iss_pc, 20);
    chk(iss_is_store == 0, "R9 iss kind", iss_is_store, 0);
    tick();
    top_is("R1 popped", 0, 0);
  endtask

  task automatic t_wait_regs();
    ins(6, 2'b01, 0, 0, 0);
    top_is("R2 waits", 0, 0);
    rr(6);
    top_is("R2 after rr", 1, 6);
    popit();
  endtask

  task automatic t_dep();
    ins(10, 2'b10, 1, 0, 0);
    ins(11, 2'b01, 0, 10, 0);
    top_is("R3 store first", 1, 10);
    chk(top_is_store == 1, "R9 top kind", top_is_store, 1);
    rr(11);
    top_is("R3 regs not enough", 1, 10);
    popit();
    top_is("R3 store pop wakes", 1, 11);
    popit();
    ins(20, 2'b10, 0, 0, 0);
    ins(21, 2'b01, 1, 20, 0);
    top_is("R3 both wait", 0, 0);
    rr(20);
    top_is("R3 store ready", 1, 20);
    popit();
    top_is("R6 mem last", 1, 21);
    popit();
    top_is("R6 drained", 0, 0);
  endtask

  task automatic t_untracked();
    ins(30, 2'b01, 1, 10, 0);
    top_is("R4 freed store no dep", 1, 30);
    popit();
    ins(31, 2'b01, 1, 29, 0);
    top_is("R4 never inserted", 1, 31);
    popit();
  endtask

  task automatic t_load_pop();
    ins(40, 2'b10, 0, 0, 0);
    ins(41, 2'b01, 1, 0, 0);
    ins(42, 2'b01, 1, 40, 0);
    top_is("R6 load top", 1, 41);
    popit();
    top_is("R6 load pop wakes none", 0, 0);
    rr(40);
    top_is("R6 store ready", 1, 40);
    popit();
    top_is("R6 dependent woken", 1, 42);
    popit();
  endtask

  task automatic t_oldest();
    ins(53, 2'b01, 1, 0, 0);
    ins(51, 2'b01, 1, 0, 0);
    ins(52, 2'b01, 1, 0, 0);
    top_is("R5 oldest a", 1, 51);
    popit();
    top_is("R5 oldest b", 1, 52);
    popit();
    top_is("R5 oldest c", 1, 53);
    popit();
  endtask

  task automatic t_nonspec();
    ins(60, 2'b01, 1, 0, 1);
    top_is("R7 held", 0, 0);
    rr(60);
    top_is("R7 rr ignored", 0, 0);
    nsr(60);
    top_is("R7 released", 1, 60);
    popit();
  endtask

  task automatic t_squash();
    ins(68, 2'b01, 1, 0, 0);
    ins(70, 2'b10, 0, 0, 0);
    ins(71, 2'b01, 1, 70, 0);
    ins(72, 2'b01, 1, 0, 0);
    top_is("R8 before", 1, 68);
    squash(69);
    top_is("R8 keeps older", 1, 68);
    popit();
    top_is("R8 younger gone", 0, 0);
    ins(75, 2'b01, 1, 70, 0);
    top_is("R8 store record gone", 1, 75);
    popit();
  endtask

  task automatic t_priority();
    ins(80, 2'b01, 1, 0, 0);
    sq_valid = 1; sq_seq = 79; pop = 1;
    ins_valid = 1; ins_seq = 81; ins_kind = 2'b01; ins_regs_rdy = 1; ins_pred_seq = 0; ins_nonspec = 0;
    #1;
    chk(iss_valid == 0, "R12 no issue", iss_valid, 0);
    tick();
    top_is("R12 squash wins", 0, 0);
    chk(err == 0, "R12 no err", err, 0);
  endtask

  task automatic t_illegal();
    ins(90, 2'b11, 1, 0, 0);
    chk(err == 1, "R10 err pulse", err, 1);
    top_is("R10 not inserted", 0, 0);
    tick();
    chk(err == 0, "R10 err clears", err, 0);
  endtask

  task automatic t_dup();
    ins(91, 2'b10, 0, 0, 0);
    chk(err == 0, "R11 first store ok", err, 0);
    ins(91, 2'b10, 1, 0, 0);
    chk(err == 1, "R11 dup store", err, 1);
    squash(90);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) ins(100 + i, 2'b01, 0, 0, 0);
    chk(full == 1, "R11 entries full", full, 1);
    ins(116, 2'b01, 1, 0, 0);
    chk(err == 1, "R11 insert when full", err, 1);
    top_is("R11 dropped", 0, 0);
    squash(99);
    chk(full == 0, "R11 entries freed", full, 0);
    for (int i = 0; i < 8; i++) ins(120 + i, 2'b10, 0, 0, 0);
    chk(full == 1, "R11 store records full", full, 1);
    squash(119);
    chk(full == 0, "R11 store records freed", full, 0);
  endtask

  task automatic t_violation();
    vio_valid = 1; vio_load_pc = 16'h1234; vio_store_pc = 16'h0abc; #1;
    chk(pv_valid == 1, "R9 pv_valid", pv_valid, 1);
    chk(pv_load_pc == 16'h1234, "R9 pv_load_pc", pv_load_pc, 16'h1234);
    chk(pv_store_pc == 16'h0abc, "R9 pv_store_pc", pv_store_pc, 16'h0abc);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_nodep();
    t_wait_regs();
    t_dep();
    t_untracked();
    t_load_pop();
    t_oldest();
    t_nonspec();
    t_squash();
    t_priority();
    t_illegal();
    t_dup();
    t_full();
    t_violation();
    finish_run();
  end
endmodule